// File: doc/BRIEF.md
# Masked Dual Alarm Interrupt Unit

This block watches a running time-of-day and raises interrupts when the time matches either of two programmable alarm sets. Each alarm set has four bytes, one each for seconds, minutes, hours and day-of-week. Bit 7 of every alarm byte is a mask: a masked field is left out of the comparison. This lets one alarm fire every second, every minute, every hour, every day or once a week.

The comparison runs only in cycles where the one-second tick is high. The surrounding clock logic raises that tick once the time fields already hold the new second. On a match, the block sets a sticky request flag for that alarm.

Any read or write of an alarm's own register bytes clears that alarm's flag. Two active-low interrupt levels are formed from the flags, the two enable bits and a routing bit in the control byte. With routing set, each alarm drives its own output. With routing clear, both alarms share output 0.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset, both request flags are 0, both interrupt outputs are high, and all eight alarm bytes read 0.
- R2: A write strobe with address 87h+n (n = 0..7) stores all 8 bits of wdata_i into alarm byte n. Bytes 0..3 are alarm 0 and bytes 4..7 are alarm 1, each in the order seconds, minutes, hours, day. The byte reads back combinationally on rdata_o at address 07h+n. A write strobe aimed at a read address (bit 7 clear) changes nothing. Any unmapped read address returns 0.
- R3: A field matches when bit 7 of its alarm byte is 1, or when alarm bits 6:0 equal time bits 6:0. An alarm's flag is set on the clock edge that ends a cycle in which tick_i is 1 and all four of its fields match. Without tick_i, no flag is set.
- R4: The mask bits select the rate. All four masked fires every second. Day masked fires daily. Day and hour masked fires hourly. Day, hour and minute masked fires once per minute. None masked fires weekly.
- R5: Flag 0 clears on the edge after any read of 07h..0Ah or write of 87h..8Ah. Flag 1 clears the same way for 0Bh..0Eh and 8Bh..8Eh. An access to one alarm leaves the other alarm's flag unchanged.
- R6: If a flag's set condition and its clearing access fall in the same cycle, the flag ends up set.
- R7: With ctrl_i[2] = 1, int0_no is low exactly when flag 0 and ctrl_i[0] are both 1, and int1_no is low exactly when flag 1 and ctrl_i[1] are both 1.
- R8: With ctrl_i[2] = 0, int0_no is low when (flag 0 and ctrl_i[0]) or (flag 1 and ctrl_i[1]), and int1_no stays high.
- R9: A flag holds until it is cleared. An enable bit of 0 keeps its flag off the outputs but does not alter the flag.
- R10: status_o, and rdata_o at address 10h, carry flag 1 in bit 1 and flag 0 in bit 0, with bits 7:2 zero.
- R11: The hours comparison includes bit 6 (12/24-hour mode) and bit 5. An alarm written for 12-hour 8 AM (48h) does not match 24-hour 08h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick; time fields are already updated |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours with mode and AM/PM bits |
| day_i | input | 8 | Current day of week, 1..7 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register address; bit 7 set means write space |
| wdata_i | input | 8 | Write data |
| ctrl_i | input | 8 | Control byte: bit 0 enable 0, bit 1 enable 1, bit 2 routing |
| rdata_o | output | 8 | Combinational read data for addr_i |
| status_o | output | 8 | Request flags in bits 1:0 |
| int0_no | output | 1 | Interrupt 0, active low |
| int1_no | output | 1 | Interrupt 1, active low |

## Verification
The bench targets the following corner cases:

- **Tick gating.** A time that matches but arrives without a tick must leave the flags at 0. A design that compared continuously would set a flag as soon as the time was written.
- **Mask granularity.** The bench applies several mask patterns. It also programs an hours byte in 12-hour format against 24-hour time. A design that dropped bits 6:5 from the hours compare would fire there.
- **Flag clearing.** Accesses to one alarm must leave the other alarm's flag intact. A tick that coincides with a clearing read must keep the flag. Swapped address windows, or clear-over-set priority, show up as a wrong status byte.
- **Routing and enables.** Routing is toggled while a flag is held. A design that fed alarm 1 to output 1 in shared mode, or let a disabled flag through, would drive the wrong interrupt level.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int DW      = 8;
  localparam int NUM_ALM = 2;
  localparam int NUM_FLD = 4;
  localparam int FLD_W   = $clog2(NUM_FLD);
  localparam int OFS_W   = DW - 1;
  localparam logic [OFS_W-1:0] ALM_BASE = 7'h07;
  localparam logic [OFS_W-1:0] STAT_OFS = 7'h10;
  // field order: 0 sec, 1 min, 2 hour, 3 day
  typedef logic [NUM_FLD-1:0][DW-1:0] fld_set_t;
endpackage

// File: rtl/alarm_bank.sv
module alarm_bank
  import alarm_irq_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [DW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output fld_set_t         regs_o,
  output logic             hit_o,
  output logic             rsel_o,
  output logic [FLD_W-1:0] fld_o
);
  localparam logic [OFS_W-1:0] LO = ALM_BASE + OFS_W'(IDX * NUM_FLD);
  localparam logic [OFS_W-1:0] HI = LO + OFS_W'(NUM_FLD - 1);

  logic             in_rng;
  logic [OFS_W-1:0] ofs;
  logic             wr_hit, rd_hit;
  fld_set_t         regs_q;

  assign ofs    = addr_i[OFS_W-1:0] - LO;
  assign in_rng = (addr_i[OFS_W-1:0] >= LO) && (addr_i[OFS_W-1:0] <= HI);
  assign wr_hit = wr_en_i && addr_i[DW-1] && in_rng;
  assign rd_hit = rd_en_i && !addr_i[DW-1] && in_rng;
  assign hit_o  = wr_hit || rd_hit;
  assign rsel_o = !addr_i[DW-1] && in_rng;
  assign fld_o  = ofs[FLD_W-1:0];
  assign regs_o = regs_q;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[f] <= '0;
      else if (wr_hit && (fld_o == FLD_W'(f))) regs_q[f] <= wdata_i;
    end
  end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_irq_pkg::*;
(
  input  fld_set_t alm_i,
  input  fld_set_t now_i,
  output logic     match_o
);
  logic [NUM_FLD-1:0] fld_ok;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_cmp
    // bit 7 masks the field out of the compare
    assign fld_ok[f] = alm_i[f][DW-1] || (alm_i[f][DW-2:0] == now_i[f][DW-2:0]);
  end

  assign match_o = &fld_ok;
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags
  import alarm_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_ALM-1:0] match_i,
  input  logic [NUM_ALM-1:0] hit_i,
  input  logic [NUM_ALM-1:0] en_i,
  input  logic               route_i,
  output logic [NUM_ALM-1:0] flag_o,
  output logic               int0_no,
  output logic               int1_no
);
  logic [NUM_ALM-1:0] flag_q;
  logic [NUM_ALM-1:0] live;

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else         flag_q[k] <= (tick_i && match_i[k]) || (flag_q[k] && !hit_i[k]);
    end
  end

  assign live    = flag_q & en_i;
  assign flag_o  = flag_q;
  assign int0_no = !(live[0] || (!route_i && live[1]));
  assign int1_no = !(route_i && live[1]);
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] min_i,
  input  logic [DW-1:0] hour_i,
  input  logic [DW-1:0] day_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ctrl_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] status_o,
  output logic          int0_no,
  output logic          int1_no
);
  fld_set_t                      now;
  fld_set_t [NUM_ALM-1:0]        regs_w;
  logic [NUM_ALM-1:0]            hit_w;
  logic [NUM_ALM-1:0]            rsel_w;
  logic [NUM_ALM-1:0][FLD_W-1:0] fld_w;
  logic [NUM_ALM-1:0]            match_w;
  logic [NUM_ALM-1:0]            flag_w;

  always_comb begin
    now[0] = sec_i;
    now[1] = min_i;
    now[2] = hour_i;
    now[3] = day_i;
  end

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    alarm_bank #(.IDX(k)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .regs_o  (regs_w[k]),
      .hit_o   (hit_w[k]),
      .rsel_o  (rsel_w[k]),
      .fld_o   (fld_w[k])
    );
    alarm_cmp u_cmp (
      .alm_i   (regs_w[k]),
      .now_i   (now),
      .match_o (match_w[k])
    );
  end

  alarm_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .match_i (match_w),
    .hit_i   (hit_w),
    .en_i    (ctrl_i[NUM_ALM-1:0]),
    .route_i (ctrl_i[2]),
    .flag_o  (flag_w),
    .int0_no (int0_no),
    .int1_no (int1_no)
  );

  assign status_o = {{(DW-NUM_ALM){1'b0}}, flag_w};

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_ALM; k++) begin
      if (rsel_w[k]) rdata_o = regs_w[k][fld_w[k]];
    end
    if (addr_i == {1'b0, STAT_OFS}) rdata_o = status_o;
  end
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk
  import alarm_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [DW-1:0]      ctrl_i,
  input logic [DW-1:0]      status_o,
  input logic               int0_no,
  input logic               int1_no,
  input logic [NUM_ALM-1:0] match_w,
  input logic [NUM_ALM-1:0] hit_w
);
  // R3, R6: a tick with a match sets the flag, even alongside a clearing access
  assert_flag0_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_w[0]) |=> status_o[0]);
  assert_flag1_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && match_w[1]) |=> status_o[1]);
  // R5: an access without a set clears the flag
  assert_flag0_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_w[0] && !(tick_i && match_w[0])) |=> !status_o[0]);
  // R9: without a set or an access the flag holds
  assert_flag1_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_w[1] && !(tick_i && match_w[1])) |=> $stable(status_o[1]));
  // R3: no tick means no rising flag
  assert_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !$rose(status_o[0]));
  // R8: shared routing leaves output 1 inactive
  assert_int1_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[2] |-> int1_no);
  // R7: enabled flag 0 drives output 0 low
  assert_int0_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && ctrl_i[0]) |-> !int0_no);
  // R10: upper status bits are zero
  assert_stat_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DW-1:NUM_ALM] == '0);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .ctrl_i   (ctrl_i),
  .status_o (status_o),
  .int0_no  (int0_no),
  .int1_no  (int1_no),
  .match_w  (match_w),
  .hit_w    (hit_w)
);

// File: tb/alarm_irq_unit_tb_top.sv
module alarm_irq_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] sec_i = '0, min_i = '0, hour_i = '0, day_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0, ctrl_i = '0;
  logic [7:0] rdata_o, status_o;
  logic       int0_no, int1_no;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alarm_irq_unit dut_i (.*);

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; addr_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i); rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i); rd_en_i = 1'b0; addr_i = '0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dy);
    @(negedge clk_i); sec_i = s; min_i = m; hour_i = h; day_i = dy;
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(status_o, 8'h00, "R1 status after reset");
    check({7'b0, int0_no}, 8'h01, "R1 int0 idle");
    check({7'b0, int1_no}, 8'h01, "R1 int1 idle");
    for (int n = 0; n < 8; n++) begin
      rd(8'h07 + 8'(n), d);
      check(d, 8'h00, "R1 alarm byte after reset");
    end
  endtask

  task automatic t_regs();
    logic [7:0] d;
    for (int n = 0; n < 8; n++) wr(8'h87 + 8'(n), 8'h11 * 8'(n + 1));
    for (int n = 0; n < 8; n++) begin
      rd(8'h07 + 8'(n), d);
      check(d, 8'h11 * 8'(n + 1), "R2 readback");
    end
    wr(8'h07, 8'h5A);
    rd(8'h07, d);
    check(d, 8'h11, "R2 write to read address ignored");
    rd(8'h11, d);
    check(d, 8'h00, "R2 unmapped read");
  endtask

  task automatic t_weekly();
    logic [7:0] d;
    ctrl_i = 8'h07;
    wr(8'h87, 8'h30); wr(8'h88, 8'h15); wr(8'h89, 8'h08); wr(8'h8A, 8'h03);
    wr(8'h8B, 8'h00); wr(8'h8C, 8'h00); wr(8'h8D, 8'h00); wr(8'h8E, 8'h00);
    set_time(8'h30, 8'h15, 8'h08, 8'h03);
    @(negedge clk_i);
    check(status_o, 8'h00, "R3 match without tick");
    set_time(8'h31, 8'h15, 8'h08, 8'h03);
    tick();
    check(status_o, 8'h00, "R3 one field differs");
    set_time(8'h30, 8'h15, 8'h08, 8'h03);
    tick();
    check(status_o, 8'h01, "R4 weekly full match");
    check({6'b0, int1_no, int0_no}, 8'h02, "R7 int0 low int1 high");
    @(negedge clk_i); @(negedge clk_i);
    check(status_o, 8'h01, "R9 flag holds");
    rd(8'h10, d);
    check(d, 8'h01, "R10 status via read port");
    rd(8'h0A, d);
    check(d, 8'h03, "R2 day byte readback");
    check(status_o, 8'h00, "R5 read clears flag 0");
    check({7'b0, int0_no}, 8'h01, "R7 int0 released");
  endtask

  task automatic t_masks();
    wr(8'h8B, 8'h30); wr(8'h8C, 8'h15); wr(8'h8D, 8'h08); wr(8'h8E, 8'h80);
    set_time(8'h30, 8'h15, 8'h08, 8'h05);
    tick();
    check(status_o, 8'h02, "R4 daily mask");
    check({6'b0, int1_no, int0_no}, 8'h01, "R7 int1 low int0 high");
    wr(8'h8B, 8'h80); wr(8'h8C, 8'h80); wr(8'h8D, 8'h80); wr(8'h8E, 8'h80);
    check(status_o, 8'h00, "R5 write clears flag 1");
    set_time(8'h59, 8'h42, 8'h17, 8'h06);
    tick();
    check(status_o, 8'h02, "R4 every second");
    wr(8'h8B, 8'h30); wr(8'h8C, 8'h15); wr(8'h8D, 8'h80); wr(8'h8E, 8'h80);
    set_time(8'h30, 8'h16, 8'h22, 8'h02);
    tick();
    check(status_o, 8'h00, "R4 hourly minute differs");
    set_time(8'h30, 8'h15, 8'h22, 8'h02);
    tick();
    check(status_o, 8'h02, "R4 hourly match");
  endtask

  task automatic t_route();
    @(negedge clk_i); ctrl_i = 8'h03;
    #1 check({6'b0, int1_no, int0_no}, 8'h02, "R8 shared routing");
    @(negedge clk_i); ctrl_i = 8'h01;
    #1 check({6'b0, int1_no, int0_no}, 8'h03, "R9 enable 1 gates");
    check(status_o, 8'h02, "R9 flag kept while disabled");
    @(negedge clk_i); ctrl_i = 8'h06;
    #1 check({6'b0, int1_no, int0_no}, 8'h01, "R7 separate routing");
  endtask

  task automatic t_clear_prio();
    logic [7:0] d;
    set_time(8'h30, 8'h15, 8'h08, 8'h03);
    tick();
    check(status_o, 8'h03, "R3 both alarms set");
    wr(8'h8C, 8'h15);
    check(status_o, 8'h01, "R5 alarm1 access keeps flag 0");
    rd(8'h07, d);
    check(status_o, 8'h00, "R5 flag 0 cleared");
    @(negedge clk_i); tick_i = 1'b1; rd_en_i = 1'b1; addr_i = 8'h07;
    @(negedge clk_i); tick_i = 1'b0; rd_en_i = 1'b0; addr_i = '0;
    check(status_o[0], 1'b1, "R6 set wins over clear");
  endtask

  task automatic t_hour_mode();
    wr(8'h89, 8'h48);
    check(status_o[0], 1'b0, "R5 hour write clears");
    set_time(8'h30, 8'h15, 8'h08, 8'h03);
    tick();
    check(status_o[0], 1'b0, "R11 12h alarm vs 24h time");
    set_time(8'h30, 8'h15, 8'h48, 8'h03);
    tick();
    check(status_o[0], 1'b1, "R11 12h alarm matches");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_weekly();
    t_masks();
    t_route();
    t_clear_prio();
    t_hour_mode();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule